// File: doc/BRIEF.md
# Back-to-Back SPI Master

This block is a single-lane SPI master working in mode 0. Software pushes words into a transmit queue. The master shifts each word out MSB first on `mosi` and captures `miso` into a receive queue, which software pops. For as long as the transmit queue holds a word, the next element starts on the very next SCK period, with no idle time between elements. One slave is picked by index, and its select line is either driven by the engine (automatic) or held at a level that software writes (manual).

The queues have a depth that is fixed at build time: 0, 16 or 256. A depth of 0 replaces each queue with a single holding register. The element length equals the data width. The number of select lines is a parameter. SCK runs at the system clock divided by an even ratio.

Top module: `spi_burst_master`

## Requirements
- R1: After reset all select lines are high, `sck` is low, `busy` is low, `tx_full` is low, `rx_empty` is high and `rx_overflow` is low.
- R2: `sck` is low whenever `busy` is low. `mosi` only changes while `sck` is low, so it is steady at every rising edge of `sck`.
- R3: One SCK period lasts `CLK_DIV` system clocks: high for `CLK_DIV/2` and low for `CLK_DIV/2`. Each element is `DATA_W` SCK pulses, with the word sent MSB first.
- R4: `miso` is sampled on each rising SCK edge, MSB first. Each completed element enters the receive queue, and `rx_data` shows the oldest entry until `rx_pop`.
- R5: While transmit data remains, the first rising edge of the next element comes exactly `CLK_DIV` clocks after the last rising edge of the previous element.
- R6: In automatic mode (`cfg_manual`=0) the line at index `cfg_ss_sel` goes low together with `busy`, `CLK_DIV/2` clocks before the first rising SCK edge. It returns high `CLK_DIV/2` clocks after the last falling edge, once the transmit side is empty.
- R7: In manual mode (`cfg_manual`=1) line `cfg_ss_sel` is low exactly when `cfg_ss_level`=1, whatever the transfer state. All other lines stay high.
- R8: An element that completes while the receive queue is full is dropped. The queued words are kept, and `rx_overflow` is set and stays set until reset.
- R9: With `FIFO_DEPTH`=0, each side holds a single word. `tx_full` rises with one word waiting behind the element in flight, and a second received word overflows.
- R10: At most one select line is low at any time.
- R11: A push while `tx_full` is high is ignored, and that word is never transmitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_push | input | 1 | Write `tx_data` into the transmit queue |
| tx_data | input | DATA_W | Word to transmit |
| tx_full | output | 1 | Transmit queue cannot take a word |
| rx_pop | input | 1 | Remove the oldest received word |
| rx_data | output | DATA_W | Oldest received word |
| rx_empty | output | 1 | Receive queue holds nothing |
| rx_overflow | output | 1 | Sticky: a received word was dropped |
| cfg_manual | input | 1 | 1 = manual select control, 0 = automatic |
| cfg_ss_sel | input | SS_W | Index of the slave to select |
| cfg_ss_level | input | 1 | Manual mode: 1 drives the chosen line low |
| sck | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | NUM_SS | Active-low slave selects |
| busy | output | 1 | An element or its trailing half period is in progress |

## Verification
The hardest condition to reach from the ports is the receive overflow together with a full transmit queue. It needs more elements to complete than the receive queue holds, with nothing popped, and a push that arrives while the transmit side is exactly full. The stimulus pushes eighteen words on consecutive clocks while the engine is still on its first element, then leaves the receive queue untouched until the burst ends. A slave model on the pins supplies the `miso` words and checks the SCK spacing at every edge. A second instance with no queues reaches the single-register full and overflow states with only two pushes.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;
   typedef enum logic [1:0] {
      ENG_IDLE = 2'd0,
      ENG_RUN  = 2'd1,
      ENG_TAIL = 2'd2
   } eng_state_t;

   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/spi_word_fifo.sv
module spi_word_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   output logic         full,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty
);
   generate
      if (DEPTH == 0) begin : g_reg
         logic [W-1:0] hold_q;
         logic         vld_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hold_q <= '0;
               vld_q  <= 1'b0;
            end else if (push && !vld_q) begin
               hold_q <= din;
               vld_q  <= 1'b1;
            end else if (pop && vld_q) begin
               vld_q  <= 1'b0;
            end
         end
         assign full  = vld_q;
         assign empty = !vld_q;
         assign dout  = hold_q;
      end else begin : g_ram
         localparam int AW = $clog2(DEPTH);
         localparam int CW = $clog2(DEPTH + 1);
         logic [W-1:0]  mem [DEPTH];
         logic [AW-1:0] wp_q, rp_q;
         logic [CW-1:0] cnt_q;
         logic          do_wr, do_rd;
         assign do_wr = push && (cnt_q != CW'(DEPTH));
         assign do_rd = pop && (cnt_q != '0);
         always_ff @(posedge clk) begin
            if (do_wr) mem[wp_q] <= din;
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               wp_q  <= '0;
               rp_q  <= '0;
               cnt_q <= '0;
            end else begin
               if (do_wr) wp_q <= wp_q + 1'b1;
               if (do_rd) rp_q <= rp_q + 1'b1;
               cnt_q <= cnt_q + CW'(do_wr) - CW'(do_rd);
            end
         end
         assign full  = (cnt_q == CW'(DEPTH));
         assign empty = (cnt_q == '0);
         assign dout  = mem[rp_q];
      end
   endgenerate
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
   import spi_burst_pkg::*;
#(
   parameter int W    = 8,
   parameter int HALF = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tx_empty,
   input  logic [W-1:0] tx_q,
   output logic         tx_pop,
   input  logic         miso,
   output logic         sck,
   output logic         mosi,
   output logic         busy,
   output logic         rx_wr,
   output logic [W-1:0] rx_word
);
   localparam int DW = idx_width(HALF);
   localparam int BW = idx_width(W);

   eng_state_t    st_q;
   logic [DW-1:0] div_q;
   logic [BW-1:0] bit_q;
   logic [W-1:0]  out_q, in_q;
   logic          sck_q;
   logic          half_done, last_fall;

   assign half_done = (div_q == DW'(HALF - 1));
   assign last_fall = (st_q == ENG_RUN) && half_done && sck_q && (bit_q == BW'(W - 1));

   assign tx_pop  = ((st_q == ENG_IDLE) || last_fall) && !tx_empty;
   assign rx_wr   = last_fall;
   assign rx_word = in_q;
   assign sck     = sck_q;
   assign mosi    = out_q[W-1];
   assign busy    = (st_q != ENG_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ENG_IDLE;
         div_q <= '0;
         bit_q <= '0;
         out_q <= '0;
         in_q  <= '0;
         sck_q <= 1'b0;
      end else begin
         case (st_q)
            ENG_IDLE: begin
               if (!tx_empty) begin
                  out_q <= tx_q;
                  st_q  <= ENG_RUN;
                  div_q <= '0;
                  bit_q <= '0;
               end
            end
            ENG_RUN: begin
               if (!half_done) begin
                  div_q <= div_q + 1'b1;
               end else begin
                  div_q <= '0;
                  if (!sck_q) begin
                     sck_q <= 1'b1;
                     in_q  <= {in_q[W-2:0], miso};
                  end else begin
                     sck_q <= 1'b0;
                     if (bit_q == BW'(W - 1)) begin
                        bit_q <= '0;
                        if (!tx_empty) out_q <= tx_q;
                        else           st_q  <= ENG_TAIL;
                     end else begin
                        bit_q <= bit_q + 1'b1;
                        out_q <= {out_q[W-2:0], 1'b0};
                     end
                  end
               end
            end
            default: begin
               if (half_done) begin
                  div_q <= '0;
                  st_q  <= ENG_IDLE;
               end else begin
                  div_q <= div_q + 1'b1;
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/spi_burst_master.sv
module spi_burst_master
   import spi_burst_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int FIFO_DEPTH = 16,
   parameter int NUM_SS     = 4,
   parameter int CLK_DIV    = 4,
   localparam int SS_W      = idx_width(NUM_SS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_push,
   input  logic [DATA_W-1:0] tx_data,
   output logic              tx_full,
   input  logic              rx_pop,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_empty,
   output logic              rx_overflow,
   input  logic              cfg_manual,
   input  logic [SS_W-1:0]   cfg_ss_sel,
   input  logic              cfg_ss_level,
   output logic              sck,
   output logic              mosi,
   input  logic              miso,
   output logic [NUM_SS-1:0] ss_n,
   output logic              busy
);
   localparam int HALF = CLK_DIV / 2;

   generate
      if (!(FIFO_DEPTH == 0 || FIFO_DEPTH == 16 || FIFO_DEPTH == 256)) begin : g_bad_depth
         $error("FIFO_DEPTH must be 0, 16 or 256");
      end
      if (CLK_DIV < 2 || (CLK_DIV % 2) != 0) begin : g_bad_div
         $error("CLK_DIV must be even and at least 2");
      end
      if (DATA_W < 2) begin : g_bad_width
         $error("DATA_W must be at least 2");
      end
      if (NUM_SS < 1) begin : g_bad_ss
         $error("NUM_SS must be at least 1");
      end
   endgenerate

   logic              tx_empty, tx_pop, rx_wr, rx_full, ovf_q, ss_on;
   logic [DATA_W-1:0] tx_q, rx_word;

   spi_word_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n), .push(tx_push), .din(tx_data), .full(tx_full),
      .pop(tx_pop), .dout(tx_q), .empty(tx_empty)
   );

   spi_word_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n), .push(rx_wr), .din(rx_word), .full(rx_full),
      .pop(rx_pop), .dout(rx_data), .empty(rx_empty)
   );

   spi_shift_engine #(.W(DATA_W), .HALF(HALF)) u_eng (
      .clk(clk), .rst_n(rst_n), .tx_empty(tx_empty), .tx_q(tx_q), .tx_pop(tx_pop),
      .miso(miso), .sck(sck), .mosi(mosi), .busy(busy), .rx_wr(rx_wr), .rx_word(rx_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              ovf_q <= 1'b0;
      else if (rx_wr && rx_full) ovf_q <= 1'b1;
   end
   assign rx_overflow = ovf_q;

   assign ss_on = cfg_manual ? cfg_ss_level : busy;

   generate
      for (genvar i = 0; i < NUM_SS; i++) begin : g_ss
         assign ss_n[i] = !(ss_on && (cfg_ss_sel == SS_W'(i)));
      end
   endgenerate
endmodule

// File: rtl/spi_burst_chk.sv
module spi_burst_chk #(
   parameter int NUM_SS = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sck,
   input logic              mosi,
   input logic              busy,
   input logic              rx_overflow,
   input logic              cfg_manual,
   input logic [NUM_SS-1:0] ss_n
);
   // R2
   idle_sck_low_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !sck);

   // R2
   mosi_stable_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(sck) |-> $stable(mosi));

   // R10
   one_ss_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(~ss_n));

   // R6
   auto_ss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_manual && sck) |-> ($countones(~ss_n) == 1));

   // R8
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) rx_overflow |=> rx_overflow);
endmodule

bind spi_burst_master spi_burst_chk #(.NUM_SS(NUM_SS)) u_chk (
   .clk(clk), .rst_n(rst_n), .sck(sck), .mosi(mosi), .busy(busy),
   .rx_overflow(rx_overflow), .cfg_manual(cfg_manual), .ss_n(ss_n)
);

// File: tb/tb_spi_burst_master.sv
module tb_spi_burst_master;
   localparam int W    = 8;
   localparam int NS   = 4;
   localparam int DIV  = 4;
   localparam int HALF = DIV / 2;
   localparam int SW   = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic          tx_push = 1'b0, rx_pop = 1'b0, miso = 1'b0;
   logic [W-1:0]  tx_data = '0;
   logic          cfg_manual = 1'b0, cfg_ss_level = 1'b0;
   logic [SW-1:0] cfg_ss_sel = '0;
   logic          tx_full, rx_empty, rx_overflow, sck, mosi, busy;
   logic [W-1:0]  rx_data;
   logic [NS-1:0] ss_n;

   spi_burst_master #(.DATA_W(W), .FIFO_DEPTH(16), .NUM_SS(NS), .CLK_DIV(DIV)) dut (
      .clk(clk), .rst_n(rst_n), .tx_push(tx_push), .tx_data(tx_data), .tx_full(tx_full),
      .rx_pop(rx_pop), .rx_data(rx_data), .rx_empty(rx_empty), .rx_overflow(rx_overflow),
      .cfg_manual(cfg_manual), .cfg_ss_sel(cfg_ss_sel), .cfg_ss_level(cfg_ss_level),
      .sck(sck), .mosi(mosi), .miso(miso), .ss_n(ss_n), .busy(busy)
   );

   // second instance without queues
   logic          z_push = 1'b0;
   logic [W-1:0]  z_data = '0;
   logic          z_full, z_empty, z_ovf, z_sck, z_mosi, z_busy;
   logic [W-1:0]  z_rx;
   logic [NS-1:0] z_ss;

   spi_burst_master #(.DATA_W(W), .FIFO_DEPTH(0), .NUM_SS(NS), .CLK_DIV(DIV)) dut0 (
      .clk(clk), .rst_n(rst_n), .tx_push(z_push), .tx_data(z_data), .tx_full(z_full),
      .rx_pop(1'b0), .rx_data(z_rx), .rx_empty(z_empty), .rx_overflow(z_ovf),
      .cfg_manual(1'b0), .cfg_ss_sel(2'd0), .cfg_ss_level(1'b0),
      .sck(z_sck), .mosi(z_mosi), .miso(1'b1), .ss_n(z_ss), .busy(z_busy)
   );

   int errs = 0;
   int checks = 0;
   int cyc = 0;
   bit done = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   endtask

   // reference slave on the pins
   logic [W-1:0] pushed_q[$];
   logic [W-1:0] mosi_got[$];
   logic [W-1:0] sent_q[$];
   logic [W-1:0] s_cur = '0, s_rx = '0;
   int  sbit = 0, sgen = 0;
   bit  loaded = 0, first = 0;
   logic prev_sck = 0, prev_busy = 0, prev_act = 0;
   int  last_rise = 0, last_fall = 0, busy_at = 0;
   int  z_rises = 0;
   logic z_prev = 0;

   always @(negedge clk) begin
      logic act;
      cyc++;
      if (cyc > 50000 && !done) begin
         errs++;
         $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 50000);
         summary();
      end
      act = !ss_n[cfg_ss_sel];
      if (rst_n) begin
         // every-clock reference comparisons
         if (!busy) chk(!sck, "R2", "sck while idle", sck, 0);
         if (cfg_manual)
            chk(ss_n == (cfg_ss_level ? ~(NS'(1) << cfg_ss_sel) : {NS{1'b1}}),
                "R7", "manual ss_n", ss_n, cfg_ss_level ? ~(NS'(1) << cfg_ss_sel) : {NS{1'b1}});
         else
            chk(ss_n == (busy ? ~(NS'(1) << cfg_ss_sel) : {NS{1'b1}}),
                "R10", "auto ss_n", ss_n, busy ? ~(NS'(1) << cfg_ss_sel) : {NS{1'b1}});
         if (busy && !prev_busy) begin busy_at = cyc; first = 1; end
         if (act && !loaded) begin
            s_cur = W'(sgen * 37 + 11); sgen++;
            miso = s_cur[W-1]; loaded = 1; sbit = 0;
         end
         if (sck && !prev_sck) begin
            if (first) begin
               if (!cfg_manual) chk(cyc - busy_at == HALF, "R6", "lead time", cyc - busy_at, HALF);
               first = 0;
            end else begin
               chk(cyc - last_rise == DIV, "R5", "rise spacing", cyc - last_rise, DIV);
            end
            s_rx = {s_rx[W-2:0], mosi};
            sbit++;
            last_rise = cyc;
         end
         if (!sck && prev_sck) begin
            chk(cyc - last_rise == HALF, "R3", "high time", cyc - last_rise, HALF);
            last_fall = cyc;
            if (sbit == W) begin
               if (act) begin
                  mosi_got.push_back(s_rx);
                  sent_q.push_back(s_cur);
               end
               sbit = 0; loaded = 0;
            end else begin
               miso = s_cur[W-1-sbit];
            end
         end
         if (!act && prev_act && !cfg_manual)
            chk(cyc - last_fall == HALF, "R6", "trail time", cyc - last_fall, HALF);
         if (!act) begin loaded = 0; sbit = 0; end
         if (z_sck && !z_prev) z_rises++;
      end
      prev_sck = sck; prev_busy = busy; prev_act = act; z_prev = z_sck;
   end

   task automatic push(input logic [W-1:0] d);
      tx_data = d; tx_push = 1'b1;
      @(negedge clk);
      tx_push = 1'b0;
   endtask

   task automatic wait_idle();
      repeat (3) @(negedge clk);
      while (busy) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   task automatic check_mosi(input string req);
      chk(mosi_got.size() == pushed_q.size(), req, "element count", mosi_got.size(), pushed_q.size());
      while (pushed_q.size() != 0 && mosi_got.size() != 0) begin
         logic [W-1:0] e, a;
         e = pushed_q.pop_front(); a = mosi_got.pop_front();
         chk(a == e, req, "mosi word", a, e);
      end
      pushed_q.delete(); mosi_got.delete();
   endtask

   task automatic drain(input string req, input int n);
      for (int i = 0; i < n; i++) begin
         logic [W-1:0] e;
         e = (sent_q.size() != 0) ? sent_q.pop_front() : '0;
         chk(!rx_empty, req, "rx has word", rx_empty, 0);
         chk(rx_data == e, req, "rx word", rx_data, e);
         rx_pop = 1'b1;
         @(negedge clk);
         rx_pop = 1'b0;
      end
      sent_q.delete();
      chk(rx_empty, req, "rx empty after drain", rx_empty, 1);
   endtask

   initial begin
      logic [W-1:0] pat[5] = '{8'h96, 8'h01, 8'h80, 8'hFF, 8'h3C};
      repeat (4) @(negedge clk);
      // R1
      chk(ss_n == '1, "R1", "ss_n reset", ss_n, 4'hF);
      chk(!sck && !busy && !tx_full, "R1", "sck/busy/full reset", {sck, busy, tx_full}, 0);
      chk(rx_empty && !rx_overflow, "R1", "rx flags reset", {rx_empty, rx_overflow}, 2'b10);
      rst_n = 1'b1;
      @(negedge clk);

      // R3 R4 R5: automatic burst on slave 1
      cfg_ss_sel = 2'd1;
      foreach (pat[i]) begin push(pat[i]); pushed_q.push_back(pat[i]); end
      wait_idle();
      check_mosi("R3");
      drain("R4", 5);

      // single element on slave 3
      cfg_ss_sel = 2'd3;
      push(8'h5A); pushed_q.push_back(8'h5A);
      wait_idle();
      check_mosi("R3");
      drain("R4", 1);

      // R7 manual mode
      cfg_manual = 1'b1; cfg_ss_sel = 2'd2; cfg_ss_level = 1'b1;
      repeat (2) @(negedge clk);
      chk(ss_n == 4'b1011, "R7", "manual low before transfer", ss_n, 4'b1011);
      push(8'hC3); pushed_q.push_back(8'hC3);
      push(8'h24); pushed_q.push_back(8'h24);
      push(8'h7E); pushed_q.push_back(8'h7E);
      wait_idle();
      chk(ss_n == 4'b1011, "R7", "manual low after transfer", ss_n, 4'b1011);
      check_mosi("R7");
      drain("R7", 3);
      cfg_ss_level = 1'b0;
      @(negedge clk);
      push(8'h11);
      wait_idle();
      chk(ss_n == 4'hF, "R7", "manual high during transfer", ss_n, 4'hF);
      rx_pop = 1'b1; @(negedge clk); rx_pop = 1'b0;
      mosi_got.delete(); sent_q.delete();

      // R11 and R8: overfill both sides in automatic mode
      cfg_manual = 1'b0; cfg_ss_sel = 2'd0;
      @(negedge clk);
      for (int i = 0; i < 17; i++) begin
         push(W'(8'h40 + i)); pushed_q.push_back(W'(8'h40 + i));
      end
      chk(tx_full, "R11", "tx_full after 17 pushes", tx_full, 1);
      push(8'hEE);
      wait_idle();
      check_mosi("R11");
      chk(rx_overflow, "R8", "overflow flag", rx_overflow, 1);
      drain("R8", 16);
      repeat (3) @(negedge clk);
      chk(rx_overflow, "R8", "overflow held", rx_overflow, 1);

      // R9 queue-less instance
      z_data = 8'hA1; z_push = 1'b1; @(negedge clk); z_push = 1'b0;
      @(negedge clk);
      z_data = 8'hB2; z_push = 1'b1; @(negedge clk); z_push = 1'b0;
      chk(z_full, "R9", "single-register full", z_full, 1);
      z_data = 8'hC3; z_push = 1'b1; @(negedge clk); z_push = 1'b0;
      repeat (3) @(negedge clk);
      while (z_busy) @(negedge clk);
      chk(z_rises == 2 * W, "R9", "two elements shifted", z_rises, 2 * W);
      chk(!z_empty && z_ovf, "R9", "second rx word overflows", {z_empty, z_ovf}, 2'b01);
      chk(z_rx == 8'hFF, "R9", "held rx word", z_rx, 8'hFF);

      done = 1;
      summary();
   end
endmodule